// File: doc/BRIEF.md
# Serial Flash Parameter-Page Erase Target

This block is the device-side command logic of a serial flash that supports one erase operation on a small parameter page. The host drives an active-low select, a serial clock and a serial data line. The block oversamples these pins with its own system clock and decodes the first byte of each select window as an opcode. It holds a status byte with a busy flag, a write-enable latch and three protection bits. The protection bits follow a non-volatile strap input.

Three opcodes are handled. A write-enable sets the latch. A status read streams the status byte on the serial output for as long as select stays low. A parameter-page erase starts a self-timed cycle of fixed length, and during that cycle the page store is filled with all ones. A power-up lockout blocks every instruction for a fixed number of clocks after reset.

The page store has a parallel read port that models the array contents. After reset every byte reads 00h, which stands for programmed data.

Top module: `spi_erase_target`

## Requirements
- R1: Opcode 05h returns the status byte on `so_o`, most significant bit first. Each bit changes after a falling `sck_i` edge, and the byte repeats while `cs_ni` stays low. The layout is bit0 busy (WIP), bit1 write-enable latch (WEL), bits4:2 the protection bits taken from `prot_i`, and bits7:5 always 0. `status_o` shows the same byte in parallel.
- R2: For `PU_CYCLES` clocks after reset is released, every instruction is ignored and `so_o` stays 0. When the lockout ends, WIP and WEL both read 0.
- R3: Opcode 06h, with `cs_ni` rising right after the eighth bit, sets WEL. Data on `si_i` is sampled on rising `sck_i`, most significant bit first.
- R4: Opcode D5h, with `cs_ni` rising right after the eighth bit, starts an erase when three conditions hold: WEL is 1, all protection bits are 0, and no erase is running. When the erase starts, WIP becomes 1 and WEL becomes 0.
- R5: An erase command is ignored while WEL is 0.
- R6: An erase command is ignored while any protection bit is 1. In that case WEL keeps its value.
- R7: An erase command is ignored if `cs_ni` rises after any bit count other than eight, for example 7 or 16.
- R8: WIP stays 1 for exactly `ERASE_CYCLES` clock cycles.
- R9: After reset every page byte reads 00h. After an erase completes, all `PAGE_BYTES` bytes read FFh.
- R10: While WIP is 1, every instruction except a status read is ignored. A status read during this time reports WIP=1 and does not change the erase length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock that oversamples the serial pins |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low chip select |
| sck_i | input | 1 | Serial clock, idle low |
| si_i | input | 1 | Serial data in |
| so_o | output | 1 | Serial data out; 0 when no status read is active |
| prot_i | input | 3 | Protection bits from non-volatile configuration |
| status_o | output | 8 | Parallel copy of the status byte |
| page_addr_i | input | ADDR_W | Page store read address |
| page_data_o | output | 8 | Page store read data |

## Verification
The assertions assume that `sck_i` and `cs_ni` each stay stable for several system clocks between edges. They also assume that `cs_ni` changes only while `sck_i` is low, so the synchronised edges keep their order. The bench drives every serial edge on a falling system clock and holds each SCK phase for six clocks. It lowers select well before the first SCK rise and raises it well after the last SCK fall. With these timings, each recorded opcode and bit count matches what the host sent.

// File: rtl/spi_erase_pkg.sv
`timescale 1ns/1ps
package spi_erase_pkg;
  localparam logic [7:0] OP_WREN  = 8'h06;
  localparam logic [7:0] OP_RDST  = 8'h05;
  localparam logic [7:0] OP_ERASE = 8'hD5;

  // bit order is visible on the serial output
  typedef struct packed {
    logic [2:0] zero;
    logic [2:0] bp;
    logic       wel;
    logic       wip;
  } status_t;
endpackage

// File: rtl/spi_erase_frontend.sv
`timescale 1ns/1ps
module spi_erase_frontend (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cs_ni,
  input  logic       sck_i,
  input  logic       si_i,
  input  logic       rd_start_i,
  input  logic [7:0] status_i,
  output logic       so_o,
  output logic       byte_done_o,
  output logic       byte_first_o,
  output logic [7:0] byte_o,
  output logic       cs_rise_o,
  output logic       exact8_o
);
  localparam int unsigned SAT = 9;

  logic [1:0] cs_ff, sck_ff, si_ff;
  logic       cs_d, sck_d;
  logic       cs_s, sck_s, si_s, active;
  logic       cs_fall, sck_rise, sck_fall;
  logic [3:0] tot_q;
  logic [2:0] bit_q;
  logic [7:0] shift_q;
  logic       done_q, first_q;
  logic       rd_q;
  logic [2:0] tx_idx_q;
  logic [7:0] tx_sh_q;
  logic       so_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cs_ff  <= 2'b11;
      sck_ff <= 2'b00;
      si_ff  <= 2'b00;
      cs_d   <= 1'b1;
      sck_d  <= 1'b0;
    end else begin
      cs_ff  <= {cs_ff[0], cs_ni};
      sck_ff <= {sck_ff[0], sck_i};
      si_ff  <= {si_ff[0], si_i};
      cs_d   <= cs_ff[1];
      sck_d  <= sck_ff[1];
    end
  end

  assign cs_s     = cs_ff[1];
  assign sck_s    = sck_ff[1];
  assign si_s     = si_ff[1];
  assign active   = ~cs_s;
  assign cs_fall  = ~cs_s & cs_d;
  assign sck_rise = active & sck_s & ~sck_d;
  assign sck_fall = active & ~sck_s & sck_d;

  // receive path
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tot_q   <= '0;
      bit_q   <= '0;
      shift_q <= '0;
      done_q  <= 1'b0;
      first_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (cs_fall) begin
        tot_q <= '0;
        bit_q <= '0;
      end else if (sck_rise) begin
        shift_q <= {shift_q[6:0], si_s};
        bit_q   <= bit_q + 3'd1;
        if (tot_q < 4'(SAT)) tot_q <= tot_q + 4'd1;
        done_q  <= (bit_q == 3'd7);
        first_q <= (tot_q < 4'd8);
      end
    end
  end

  assign byte_done_o  = done_q;
  assign byte_first_o = first_q;
  assign byte_o       = shift_q;
  assign cs_rise_o    = cs_s & ~cs_d;
  assign exact8_o     = (tot_q == 4'd8);

  // transmit path, status byte repeats per 8 falling edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_q     <= 1'b0;
      tx_idx_q <= '0;
      tx_sh_q  <= '0;
      so_q     <= 1'b0;
    end else if (!active) begin
      rd_q     <= 1'b0;
      tx_idx_q <= '0;
      so_q     <= 1'b0;
    end else begin
      if (rd_start_i) rd_q <= 1'b1;
      if (rd_q && sck_fall) begin
        tx_idx_q <= tx_idx_q + 3'd1;
        if (tx_idx_q == 3'd0) begin
          so_q    <= status_i[7];
          tx_sh_q <= {status_i[6:0], 1'b0};
        end else begin
          so_q    <= tx_sh_q[7];
          tx_sh_q <= {tx_sh_q[6:0], 1'b0};
        end
      end
    end
  end

  assign so_o = so_q;
endmodule

// File: rtl/spi_erase_ctrl.sv
`timescale 1ns/1ps
module spi_erase_ctrl
  import spi_erase_pkg::*;
#(
  parameter int unsigned PU_CYCLES    = 500,
  parameter int unsigned ERASE_CYCLES = 600,
  parameter int unsigned PAGE_BYTES   = 256,
  localparam int unsigned ADDR_W = $clog2(PAGE_BYTES),
  localparam int unsigned PU_W   = $clog2(PU_CYCLES + 1),
  localparam int unsigned TMR_W  = $clog2(ERASE_CYCLES + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [2:0]        prot_i,
  input  logic              byte_done_i,
  input  logic              byte_first_i,
  input  logic [7:0]        byte_i,
  input  logic              cs_rise_i,
  input  logic              exact8_i,
  output logic              rd_start_o,
  output status_t           status_o,
  output logic              ready_o,
  output logic              fill_we_o,
  output logic [ADDR_W-1:0] fill_addr_o
);
  logic [PU_W-1:0]   pu_cnt_q;
  logic              ready_q;
  logic [7:0]        op_q;
  logic              wel_q, wip_q;
  logic [2:0]        bp_q;
  logic [TMR_W-1:0]  tmr_q;
  logic              fill_q;
  logic [ADDR_W-1:0] fill_addr_q;
  logic              cmd_end, wren_go, erase_go;

  // power-up lockout
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pu_cnt_q <= '0;
      ready_q  <= 1'b0;
    end else if (!ready_q) begin
      if (pu_cnt_q == PU_W'(PU_CYCLES - 1)) ready_q <= 1'b1;
      else pu_cnt_q <= pu_cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) op_q <= '0;
    else if (byte_done_i && byte_first_i) op_q <= byte_i;
  end

  assign rd_start_o = ready_q && byte_done_i && byte_first_i && (byte_i == OP_RDST);
  assign cmd_end    = ready_q && cs_rise_i && exact8_i && !wip_q;
  assign wren_go    = cmd_end && (op_q == OP_WREN);
  assign erase_go   = cmd_end && (op_q == OP_ERASE) && wel_q && (bp_q == 3'b000);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bp_q  <= '0;
      wel_q <= 1'b0;
    end else begin
      if (ready_q) bp_q <= prot_i;
      if (erase_go) wel_q <= 1'b0;
      else if (wren_go) wel_q <= 1'b1;
    end
  end

  // self-timed erase and page fill
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wip_q       <= 1'b0;
      tmr_q       <= '0;
      fill_q      <= 1'b0;
      fill_addr_q <= '0;
    end else if (erase_go) begin
      wip_q       <= 1'b1;
      tmr_q       <= TMR_W'(ERASE_CYCLES - 1);
      fill_q      <= 1'b1;
      fill_addr_q <= '0;
    end else if (wip_q) begin
      if (tmr_q == '0) wip_q <= 1'b0;
      else tmr_q <= tmr_q - 1'b1;
      if (fill_q) begin
        if (fill_addr_q == ADDR_W'(PAGE_BYTES - 1)) fill_q <= 1'b0;
        else fill_addr_q <= fill_addr_q + 1'b1;
      end
    end
  end

  assign fill_we_o   = wip_q && fill_q;
  assign fill_addr_o = fill_addr_q;
  assign ready_o     = ready_q;

  always_comb begin
    status_o      = '0;
    status_o.wip  = wip_q;
    status_o.wel  = wel_q;
    status_o.bp   = bp_q;
  end
endmodule

// File: rtl/spi_erase_page.sv
`timescale 1ns/1ps
module spi_erase_page #(
  parameter int unsigned PAGE_BYTES = 256,
  localparam int unsigned ADDR_W = $clog2(PAGE_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fill_we_i,
  input  logic [ADDR_W-1:0] fill_addr_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [7:0]        rd_data_o
);
  logic [7:0] mem_q [PAGE_BYTES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < int'(PAGE_BYTES); i++) mem_q[i] <= 8'h00;
    end else if (fill_we_i) begin
      mem_q[fill_addr_i] <= 8'hFF;
    end
  end

  assign rd_data_o = mem_q[rd_addr_i];
endmodule

// File: rtl/spi_erase_target.sv
`timescale 1ns/1ps
module spi_erase_target
  import spi_erase_pkg::*;
#(
  parameter int unsigned PU_CYCLES    = 500,
  parameter int unsigned ERASE_CYCLES = 600,
  parameter int unsigned PAGE_BYTES   = 256,
  localparam int unsigned ADDR_W = $clog2(PAGE_BYTES)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              sck_i,
  input  logic              si_i,
  output logic              so_o,
  input  logic [2:0]        prot_i,
  output logic [7:0]        status_o,
  input  logic [ADDR_W-1:0] page_addr_i,
  output logic [7:0]        page_data_o
);
  logic              byte_done, byte_first, cs_rise, exact8, rd_start;
  logic [7:0]        rx_byte;
  status_t           status;
  logic              ready;
  logic              fill_we;
  logic [ADDR_W-1:0] fill_addr;

  spi_erase_frontend u_fe (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .cs_ni        (cs_ni),
    .sck_i        (sck_i),
    .si_i         (si_i),
    .rd_start_i   (rd_start),
    .status_i     (status),
    .so_o         (so_o),
    .byte_done_o  (byte_done),
    .byte_first_o (byte_first),
    .byte_o       (rx_byte),
    .cs_rise_o    (cs_rise),
    .exact8_o     (exact8)
  );

  spi_erase_ctrl #(
    .PU_CYCLES    (PU_CYCLES),
    .ERASE_CYCLES (ERASE_CYCLES),
    .PAGE_BYTES   (PAGE_BYTES)
  ) u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .prot_i       (prot_i),
    .byte_done_i  (byte_done),
    .byte_first_i (byte_first),
    .byte_i       (rx_byte),
    .cs_rise_i    (cs_rise),
    .exact8_i     (exact8),
    .rd_start_o   (rd_start),
    .status_o     (status),
    .ready_o      (ready),
    .fill_we_o    (fill_we),
    .fill_addr_o  (fill_addr)
  );

  spi_erase_page #(.PAGE_BYTES(PAGE_BYTES)) u_page (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .fill_we_i   (fill_we),
    .fill_addr_i (fill_addr),
    .rd_addr_i   (page_addr_i),
    .rd_data_o   (page_data_o)
  );

  assign status_o = status;
endmodule

// File: rtl/spi_erase_target_chk.sv
`timescale 1ns/1ps
module spi_erase_target_chk #(
  parameter int unsigned ERASE_CYCLES = 600
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       ready_i,
  input logic       wip_i,
  input logic       wel_i,
  input logic [2:0] bp_i,
  input logic       fill_we_i,
  input logic       cs_rise_i,
  input logic       exact8_i
);
  logic [31:0] busy_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) busy_cnt_q <= '0;
    else if (wip_i) busy_cnt_q <= busy_cnt_q + 32'd1;
    else busy_cnt_q <= '0;
  end

  AST_LOCKOUT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ready_i |-> (!wip_i && !wel_i)); // R2
  AST_ERASE_CLEARS_WEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wip_i) |-> !wel_i); // R4
  AST_ERASE_NEEDS_WEL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wip_i) |-> $past(wel_i)); // R5
  AST_ERASE_NEEDS_UNPROT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wip_i) |-> ($past(bp_i) == 3'b000)); // R6
  AST_ERASE_ON_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wip_i) |-> $past(cs_rise_i && exact8_i)); // R7
  AST_ERASE_LENGTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(wip_i) |-> (busy_cnt_q == ERASE_CYCLES)); // R8
  AST_FILL_IN_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fill_we_i |-> wip_i); // R9
  AST_NO_WEL_WHILE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(wel_i) |-> (!wip_i && !$past(wip_i))); // R10
endmodule

bind spi_erase_target spi_erase_target_chk #(.ERASE_CYCLES(ERASE_CYCLES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .ready_i   (ready),
  .wip_i     (status.wip),
  .wel_i     (status.wel),
  .bp_i      (status.bp),
  .fill_we_i (fill_we),
  .cs_rise_i (cs_rise),
  .exact8_i  (exact8)
);

// File: tb/spi_erase_target_test.sv
`timescale 1ns/1ps
module spi_erase_target_test;
  localparam int unsigned PU    = 400;
  localparam int unsigned ERASE = 600;
  localparam int unsigned PAGE  = 256;
  localparam int unsigned AW    = $clog2(PAGE);
  localparam int unsigned H     = 6;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          cs_n = 1'b1, sck = 1'b0, si = 1'b0;
  logic          so;
  logic [2:0]    prot = 3'b000;
  logic [7:0]    status;
  logic [AW-1:0] paddr = '0;
  logic [7:0]    pdata;

  int n_chk = 0, n_fail = 0;
  int run_len = 0, last_len = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  spi_erase_target #(.PU_CYCLES(PU), .ERASE_CYCLES(ERASE), .PAGE_BYTES(PAGE)) uut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .sck_i(sck), .si_i(si), .so_o(so),
    .prot_i(prot), .status_o(status), .page_addr_i(paddr), .page_data_o(pdata)
  );

  // busy-length monitor
  always @(negedge clk) begin
    if (status[0]) run_len++;
    else if (run_len != 0) begin
      last_len = run_len;
      run_len  = 0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic put_bit(input logic b);
    si = b;
    wait_clk(H);
    sck = 1'b1;
    wait_clk(H);
    sck = 1'b0;
  endtask

  // send n bits of val, starting at val[15]
  task automatic spi_bits(input logic [15:0] val, input int n);
    @(negedge clk);
    cs_n = 1'b0;
    wait_clk(H);
    for (int i = 0; i < n; i++) put_bit(val[15-i]);
    wait_clk(H);
    cs_n = 1'b1;
    wait_clk(2*H);
  endtask

  task automatic spi_cmd(input logic [7:0] op);
    spi_bits({op, 8'h00}, 8);
  endtask

  task automatic read_status(output logic [7:0] b0, output logic [7:0] b1);
    logic [15:0] cap;
    @(negedge clk);
    cs_n = 1'b0;
    wait_clk(H);
    for (int i = 0; i < 8; i++) put_bit(i == 5 || i == 7);  // 05h
    for (int i = 0; i < 16; i++) begin
      wait_clk(H);
      cap[15-i] = so;
      sck = 1'b1;
      wait_clk(H);
      sck = 1'b0;
    end
    wait_clk(H);
    cs_n = 1'b1;
    wait_clk(2*H);
    b0 = cap[15:8];
    b1 = cap[7:0];
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 4*ERASE && status[0]; i++) @(negedge clk);
  endtask

  task automatic t_reset_lockout();
    logic [7:0] r0, r1;
    check("R2 reset status", status, 8'h00);
    paddr = 8'd0;   #1 check("R9 page reset byte 0", pdata, 8'h00);
    paddr = 8'd255; #1 check("R9 page reset byte 255", pdata, 8'h00);
    spi_cmd(8'h06);
    check("R2 wren ignored in lockout", status[1], 1'b0);
    read_status(r0, r1);
    check("R2 status read silent in lockout", {r0, r1}, 16'h0000);
    wait_clk(PU);
    check("R2 idle after lockout", status[1:0], 2'b00);
  endtask

  task automatic t_wren_status();
    logic [7:0] r0, r1;
    prot = 3'b101;
    spi_cmd(8'h06);
    check("R3 wren sets wel", status[1], 1'b1);
    read_status(r0, r1);
    check("R1 status byte", r0, 8'h16);
    check("R1 status repeats", r1, 8'h16);
    check("R1 parallel status", status, 8'h16);
  endtask

  task automatic t_refusals();
    prot = 3'b010;
    spi_cmd(8'hD5);
    check("R6 protected erase ignored", status[0], 1'b0);
    check("R6 wel kept", status[1], 1'b1);
    prot = 3'b000;
    wait_clk(2);
    spi_bits(16'hD500, 7);
    check("R7 seven bits no erase", status[0], 1'b0);
    spi_bits(16'hD5D5, 16);
    check("R7 sixteen bits no erase", status[0], 1'b0);
    check("R7 wel unchanged", status[1], 1'b1);
  endtask

  task automatic t_no_wel();
    // WEL is cleared only by an erase, so use a fresh reset
    rst_n = 1'b0;
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(PU + 4);
    spi_cmd(8'hD5);
    check("R5 erase without wel ignored", status[0], 1'b0);
  endtask

  task automatic t_erase();
    int bad;
    spi_cmd(8'h06);
    spi_cmd(8'hD5);
    check("R4 erase starts wip", status[0], 1'b1);
    check("R4 erase clears wel", status[1], 1'b0);
    wait_idle();
    wait_clk(2);
    check("R8 busy length", last_len, ERASE);
    bad = 0;
    for (int a = 0; a < int'(PAGE); a++) begin
      paddr = AW'(a);
      #1 if (pdata !== 8'hFF) bad++;
    end
    check("R9 page all ones", bad, 0);
  endtask

  task automatic t_busy();
    logic [7:0] r0, r1;
    spi_cmd(8'h06);
    spi_cmd(8'hD5);
    spi_cmd(8'h06);
    check("R10 wren ignored while busy", status[1], 1'b0);
    read_status(r0, r1);
    check("R10 status read while busy", r0, 8'h01);
    check("R10 busy status repeats", r1, 8'h01);
    wait_idle();
    wait_clk(2);
    check("R10 R8 length kept with read", last_len, ERASE);
  endtask

  initial begin
    wait_clk(4);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset_lockout();
    t_wren_status();
    t_refusals();
    t_no_wel();
    t_erase();
    t_busy();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    #500000;
    if (!done) begin
      done = 1;
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule